// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the slave side of a three-wire serial memory bus: chip select, serial clock and serial data in, plus a data-out pin with a separate output-enable for a tri-state pad. It holds 256 words of 16 bits in registers. A command frame begins with a start bit, followed by a two-bit opcode and an eight-bit address. The block serves sequential reads, single-word writes, and a command pair that turns write protection on and off. Chip select and the serial clock are slow pins. They pass through a synchronizer into one fast system clock, and all decoding runs on edges found in that domain.

A write is only collected while the serial clock runs. The word is programmed at the falling edge of chip select that follows the last data bit. Programming then takes a parameterised number of system clocks. During that time the master may raise chip select and watch the data-out pin: it reads low while the block is busy and high once it is ready. A read returns one leading zero and then the addressed word. Reads keep streaming the following words for as long as the clock runs with chip select held high.

Top module: `mwire_mem_slave`

## Requirements
- R1: While chip select is high and no command is in progress, serial-clock rising edges that sample 0 on data-in are ignored. The first edge that samples 1 is the start bit.
- R2: Opcode bits arrive MSB first after the start bit. Opcode 10 is a read. The 8 address bits follow, A7 first. At the edge that samples A0, data-out is driven with output-enable high and value 0. The next 16 rising edges drive D15 down to D0.
- R3: If clocking continues with chip select high after D0, the address increments by one and the next word follows with no leading zero. Address 255 wraps to 0.
- R4: Opcode 01 is a write. Sixteen data bits, D15 first, follow the address. The word is stored at the falling edge of chip select after D0. If chip select falls before D0, nothing is stored.
- R5: Opcode 00 is the protection group. Address bits A7,A6 = 11 enable writes and 00 disable them. Codes 01 and 10 change nothing. Any further bits until chip select falls are ignored. After reset, writes are disabled.
- R6: A write while disabled leaves the memory unchanged and starts no busy period. On the next chip select high, data-out stays released.
- R7: From a stored write until the first falling edge of chip select after programming ends, chip select high drives output-enable high. Data-out is then 0 while busy and 1 when ready. Serial input is ignored during this window.
- R8: Programming lasts BUSY_CYCLES system clocks from the detected chip-select fall. Commands sent during that time, including protection commands, have no effect.
- R9: Output-enable is low after reset, whenever chip select is low, and at all times other than read data and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output-enable for the data-out pad |

## Verification
Every serial pin passes two synchronizer flops and one edge-detect flop. A data-out change caused by a serial clock rise therefore appears about three to four system clocks after that rise. The bench holds each clock phase for six system clocks and samples data-out on the falling system clock half a cycle after the serial clock returns low, which leaves several cycles of slack. The busy period is measured from the moment the bench drops chip select until data-out first reads 1. That span must fall between BUSY_CYCLES and BUSY_CYCLES plus ten, which covers the synchronizer and output register delays. A behavioural memory and enable flag in the bench predict every read word and every status response. A per-clock monitor checks that data-out stays released once chip select has been low for six clocks.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_WPEND,
    ST_SKIP
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } mw_op_e;

  localparam logic [1:0] CTRL_ENABLE  = 2'b11;
  localparam logic [1:0] CTRL_DISABLE = 2'b00;
  localparam int         OPC_BITS     = 2;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] f_tick(input logic [CW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else            cnt <= f_tick(cnt);
  end

  assign busy = (cnt != '0);

  // R8: the countdown never exceeds its programmed length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYCLES));

  // R8: a new programming cycle is never requested while one runs
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mwire_mem_slave.sv
module mwire_mem_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int SPAN  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(SPAN);
  localparam int BIT_W = $clog2(DATA_W);

  function automatic logic [ADDR_W-1:0] f_next_addr(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] f_shift_addr(input logic [ADDR_W-1:0] a,
                                                      input logic b);
    return {a[ADDR_W-2:0], b};
  endfunction

  function automatic logic [DATA_W-1:0] f_shift_data(input logic [DATA_W-1:0] d,
                                                      input logic b);
    return {d[DATA_W-2:0], b};
  endfunction

  // synchronized pins and edges
  logic [2:0] sync_q;
  logic       cs_s, sk_s, sdi_s, cs_d, sk_d;
  logic       sk_rise, cs_fall;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_i, sclk_i, sdi_i}),
    .q     (sync_q)
  );

  assign cs_s  = sync_q[2];
  assign sk_s  = sync_q[1];
  assign sdi_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_d <= cs_s;
      sk_d <= sk_s;
    end
  end

  assign sk_rise = sk_s & ~sk_d;
  assign cs_fall = ~cs_s & cs_d;

  // command state
  mw_state_e         state_q;
  mw_op_e            op_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BIT_W-1:0]  rd_bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;
  logic              wen_q, status_q, busy;

  // named internal events
  logic       accept, rd_launch, rd_step, ctrl_hit, wen_set, wen_clr, wr_fire;
  logic [1:0] ctrl_code;

  assign accept    = cs_s && !busy && !status_q && sk_rise;
  assign rd_launch = accept && (state_q == ST_ADDR) && (bitcnt_q == '0) && (op_q == OP_READ);
  assign rd_step   = accept && (state_q == ST_RDATA);
  assign ctrl_hit  = accept && (state_q == ST_ADDR) && (op_q == OP_CTRL)
                     && (bitcnt_q == CNT_W'(ADDR_W - 2));
  assign ctrl_code = {addr_q[0], sdi_s};
  assign wen_set   = ctrl_hit && (ctrl_code == CTRL_ENABLE);
  assign wen_clr   = ctrl_hit && (ctrl_code == CTRL_DISABLE);
  assign wr_fire   = cs_fall && (state_q == ST_WPEND) && wen_q;

  mw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_fire),
    .busy  (busy)
  );

  mw_word_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (addr_q),
    .wdata (wdata_q),
    .raddr (addr_q),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_CTRL;
      bitcnt_q <= '0;
      rd_bit_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (!cs_s || busy || status_q) begin
      state_q <= ST_IDLE;
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: begin
          if (sdi_s) begin
            state_q  <= ST_OPC;
            bitcnt_q <= CNT_W'(OPC_BITS - 1);
          end
        end
        ST_OPC: begin
          op_q <= mw_op_e'({op_q[0], sdi_s});
          if (bitcnt_q == '0) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= CNT_W'(ADDR_W - 1);
          end else begin
            bitcnt_q <= bitcnt_q - 1'b1;
          end
        end
        ST_ADDR: begin
          addr_q <= f_shift_addr(addr_q, sdi_s);
          if (ctrl_hit) begin
            state_q <= ST_SKIP;
          end else if (bitcnt_q == '0) begin
            case (op_q)
              OP_READ: begin
                state_q  <= ST_RDATA;
                rd_bit_q <= BIT_W'(DATA_W - 1);
              end
              OP_WRITE: begin
                state_q  <= ST_WDATA;
                bitcnt_q <= CNT_W'(DATA_W - 1);
              end
              default: state_q <= ST_SKIP;
            endcase
          end else begin
            bitcnt_q <= bitcnt_q - 1'b1;
          end
        end
        ST_WDATA: begin
          wdata_q <= f_shift_data(wdata_q, sdi_s);
          if (bitcnt_q == '0) state_q <= ST_WPEND;
          else                bitcnt_q <= bitcnt_q - 1'b1;
        end
        ST_RDATA: begin
          if (rd_bit_q == '0) begin
            rd_bit_q <= BIT_W'(DATA_W - 1);
            addr_q   <= f_next_addr(addr_q);
          end else begin
            rd_bit_q <= rd_bit_q - 1'b1;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // protection flag and status window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wen_set)      wen_q <= 1'b1;
      else if (wen_clr) wen_q <= 1'b0;
      if (wr_fire)               status_q <= 1'b1;
      else if (cs_fall && !busy) status_q <= 1'b0;
    end
  end

  // data-out pad
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (!cs_s) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (status_q) begin
      sdo_o    <= !busy;
      sdo_oe_o <= 1'b1;
    end else if (rd_launch) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b1;
    end else if (rd_step) begin
      sdo_o    <= rdata[rd_bit_q];
      sdo_oe_o <= 1'b1;
    end
  end

  // R9: a low chip select releases the pad on the next cycle
  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdo_oe_o);

  // R7: status window drives busy as 0 and ready as 1
  p_status_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && cs_s) |=> (sdo_oe_o && (sdo_o == !$past(busy))));

  // R8: no command decoding while programming
  p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state_q == ST_IDLE));

  // R6: programming only starts with writes enabled
  p_write_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // R3: the address steps by one after each streamed word
  p_read_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && (rd_bit_q == '0)) |=> (addr_q == f_next_addr($past(addr_q))));
endmodule

// File: tb/sim_mwire_mem_slave.sv
module sim_mwire_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int BUSY       = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int t_fall   = 0;
  int cs_low_run = 0;

  logic [15:0] ref_mem [256];
  bit          ref_wen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mwire_mem_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R9: per-clock monitor of the released pad
  always @(negedge clk) begin
    if (!rst_n || cs) cs_low_run = 0;
    else cs_low_run++;
    if (cs_low_run >= 6) check(oe == 1'b0, "R9", "oe with cs low", oe, 0);
  end

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cs_set(input logic v);
    cs = v;
    if (!v) t_fall = cyc;
    clk_n(HALF);
  endtask

  task automatic sk_bit(input logic b, output logic so, output logic soe);
    sdi = b;
    clk_n(HALF);
    sclk = 1'b1;
    clk_n(HALF);
    sclk = 1'b0;
    @(negedge clk);
    so  = sdo;
    soe = oe;
  endtask

  task automatic send(input int val, input int n);
    logic so, soe;
    for (int i = n - 1; i >= 0; i--) sk_bit(val[i], so, soe);
  endtask

  task automatic do_read(input int addr, input int nwords, input int lead);
    logic so, soe;
    logic [15:0] word;
    bit all_oe;
    cs_set(1);
    send(0, lead);
    send(3'b110, 3);
    send(addr >> 1, 7);
    sk_bit(addr[0], so, soe);
    check(so == 1'b0 && soe == 1'b1, "R2", "dummy bit {sdo,oe}", {so, soe}, 2'b01);
    for (int w = 0; w < nwords; w++) begin
      all_oe = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        sk_bit(1'b0, so, soe);
        word[b] = so;
        all_oe &= soe;
      end
      check(word == ref_mem[(addr + w) & 255] && all_oe,
            (w == 0) ? "R2" : "R3", "read word", word, ref_mem[(addr + w) & 255]);
    end
    cs_set(0);
  endtask

  task automatic do_write(input int addr, input int data, input int nbits);
    cs_set(1);
    send(3'b101, 3);
    send(addr, 8);
    send(data >> (16 - nbits), nbits);
    cs_set(0);
    t_fall = t_fall;
    if (nbits == 16 && ref_wen) ref_mem[addr] = data[15:0];
  endtask

  task automatic do_ctrl(input int code, input int lead);
    cs_set(1);
    send(0, lead);
    send(3'b100, 3);
    send(code, 2);
    send(6'b101101, 6);
    cs_set(0);
    if (code == 3) ref_wen = 1'b1;
    else if (code == 0) ref_wen = 1'b0;
  endtask

  task automatic expect_no_status(input string req);
    cs_set(1);
    check(oe == 1'b0, req, "no status after write", oe, 0);
    cs_set(0);
  endtask

  task automatic poll_ready();
    int spent;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < BUSY + 100 && !seen; i++) begin
      @(negedge clk);
      if (sdo && oe) seen = 1'b1;
    end
    spent = cyc - t_fall;
    check(seen, "R7", "ready seen", seen, 1);
    check(spent >= BUSY && spent <= BUSY + 10, "R8", "busy length", spent, BUSY);
    cs_set(0);
  endtask

  task automatic wait_ready();
    cs_set(1);
    check(oe == 1'b1 && sdo == 1'b0, "R7", "busy {sdo,oe}", {sdo, oe}, 2'b01);
    poll_ready();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 16'h0;
    clk_n(4);
    @(negedge clk);
    check(oe == 1'b0, "R9", "oe at reset", oe, 0);
    rst_n = 1'b1;
    clk_n(4);

    do_read(5, 1, 0);                     // R2 reset contents
    do_write(8'h10, 16'hA5A5, 16);        // R6 disabled after reset (R5)
    expect_no_status("R6");
    do_read(8'h10, 1, 0);

    do_ctrl(3, 3);                        // R1 leading zeros, R5 enable
    do_write(8'h10, 16'h1234, 16);        // R4
    wait_ready();

    // R8: protection command during busy must be ignored
    do_write(8'h11, 16'hBEEF, 16);
    cs_set(1);
    check(oe == 1'b1 && sdo == 1'b0, "R7", "busy {sdo,oe}", {sdo, oe}, 2'b01);
    send(5'b10000, 5);
    send(4'b1010, 4);
    check(oe == 1'b1 && sdo == 1'b0, "R8", "still busy during input", {sdo, oe}, 2'b01);
    poll_ready();
    do_write(8'hFF, 16'h0F0F, 16);        // succeeds only if the disable was ignored
    wait_ready();

    do_read(8'h10, 2, 0);                 // R3 increment
    do_read(8'hFF, 2, 2);                 // R3 wrap, R1 leading zeros

    do_write(8'h12, 16'h5555, 10);        // R4 cut short
    expect_no_status("R4");
    do_read(8'h12, 1, 0);

    do_ctrl(1, 0);                        // R5 code 01 changes nothing
    do_write(8'h13, 16'h7777, 16);
    wait_ready();
    do_read(8'h13, 1, 0);

    do_ctrl(0, 1);                        // R5 disable
    do_write(8'h14, 16'h9999, 16);
    expect_no_status("R6");
    do_read(8'h14, 1, 0);

    clk_n(10);
    summary();
    $finish;
  end
endmodule